// File: doc/BRIEF.md
# Background Comparator Offset Trim Controller

This block trims the input offset of every comparator in a flash converter bank without stopping conversion. It works on one comparator at a time. For the selected comparator it drives a chop signal that swaps the polarity of the input and output chopper pair together. It XORs the decision bit it receives with that chop state, so the converter signal becomes a high-frequency term and the offset becomes a DC term. It then sums the result as +1 or -1 over a fixed window of samples, and the sign of the sum sets one bit of a 6-bit trim code. The trim code is found by binary search, most significant bit first, with one window per bit.

When the last bit is resolved, the final code goes into a register file that holds one trim code per comparator. A one-cycle completion pulse carries the comparator index and its code, and service moves on to the next comparator, wrapping from the last one back to the first. The trial code for the comparator being searched is presented on its own output. The stored codes of all comparators are presented on a flat bus, and the converter applies them to its trim capacitors.

Top module: `offset_cal_ctrl`

## Requirements
- R1: A synchronous active-high reset loads every stored trim code with mid-scale (binary 100000, value 32), selects comparator 0, sets the trial code to 32, and holds chop and the completion pulse at 0.
- R2: The chop output toggles on every sample. It is 0 on the first sample of each window, so each window of WIN_LEN (even) samples has equal numbers of chopped and straight samples.
- R3: Each sample adds +1 to the window sum when the selected comparator's decision XOR chop is 1, and adds -1 when it is 0.
- R4: Each search starts at trial code 32 and resolves one bit per window, MSB first. A window sum above zero clears the bit under trial, a sum of zero or below keeps it, and the next lower bit is then set to 1. For a comparator whose residual offset is (offset + code - 32), this gives the largest code whose residual is not positive, clamped to 0..63. A new search starts at 32 again.
- R5: A comparator's calibration lasts exactly TRIM_W*WIN_LEN cycles, and the completion pulse is high for one cycle.
- R6: While the completion pulse is high, the index output names the comparator just finished, the code output carries its final code, and the stored code for that comparator already equals that final code.
- R7: On completion the selected index advances by one and wraps from NUM_CMP-1 to 0. It does not change at any other time.
- R8: Decision bits of comparators that are not selected have no effect on the outcome of the search.
- R9: Stored codes of comparators other than the one just completed keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_dec | input | NUM_CMP | Decision bits of the comparator bank, after the output-side chopper |
| chop | output | 1 | Chopper control for the selected comparator |
| sel_idx | output | IDX_W | Index of the comparator under calibration |
| trim_trial | output | TRIM_W | Trial trim code for the selected comparator |
| trim_bank | output | NUM_CMP*TRIM_W | Stored trim codes, entry i at bits i*TRIM_W upward |
| done | output | 1 | One-cycle completion pulse |
| done_idx | output | IDX_W | Index of the comparator just finished |
| done_code | output | TRIM_W | Final trim code of that comparator |

## Verification
A behavioural comparator model gives each comparator its own offset and responds to chop and to the trim code it receives. The stimulus table sweeps zero offset, where the window sum ties at zero and the tie rule is exposed, small offsets of either sign, which test the low bits of the search, and offsets beyond full range, which must saturate at 0 or 63. A second sweep assigns new offsets to the same comparators after wrap-around, which shows that old codes are replaced and that the index returns to 0. The unselected decision bits carry pseudo-random noise throughout, so any leak from them shifts a final code. A reset in the middle of a search then checks that the register file is cleared and that the search restarts cleanly.

// File: rtl/offset_cal_ctrl.sv
module offset_cal_ctrl #(
  parameter int NUM_CMP = 63,
  parameter int TRIM_W  = 6,
  parameter int WIN_LEN = 1000,
  localparam int IDX_W  = $clog2(NUM_CMP)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_CMP-1:0]        cmp_dec,
  output logic                      chop,
  output logic [IDX_W-1:0]          sel_idx,
  output logic [TRIM_W-1:0]         trim_trial,
  output logic [NUM_CMP*TRIM_W-1:0] trim_bank,
  output logic                      done,
  output logic [IDX_W-1:0]          done_idx,
  output logic [TRIM_W-1:0]         done_code
);
  localparam int CNT_W = $clog2(WIN_LEN);
  localparam int ACC_W = $clog2(WIN_LEN + 1) + 1;
  localparam int BIT_W = (TRIM_W > 1) ? $clog2(TRIM_W) : 1;
  localparam logic [TRIM_W-1:0] MID = TRIM_W'(1) << (TRIM_W - 1);

  logic [CNT_W-1:0]        cnt;
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] sum;
  logic [BIT_W-1:0]        bitp;
  logic [TRIM_W-1:0]       mask;
  logic [TRIM_W-1:0]       decided;
  logic [IDX_W-1:0]        sel_next;
  logic [TRIM_W-1:0]       bank [NUM_CMP];
  logic                    dechop;
  logic                    last;

  assign dechop   = cmp_dec[sel_idx] ^ chop;
  assign sum      = dechop ? acc + ACC_W'(1) : acc - ACC_W'(1);
  assign last     = (cnt == CNT_W'(WIN_LEN - 1));
  assign mask     = TRIM_W'(1) << bitp;
  assign decided  = (sum > 0) ? (trim_trial & ~mask) : trim_trial;
  assign sel_next = (sel_idx == IDX_W'(NUM_CMP - 1)) ? '0 : sel_idx + 1'b1;

  generate
    for (genvar g = 0; g < NUM_CMP; g++) begin : g_bank
      assign trim_bank[g*TRIM_W +: TRIM_W] = bank[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      acc        <= '0;
      chop       <= 1'b0;
      bitp       <= BIT_W'(TRIM_W - 1);
      trim_trial <= MID;
      sel_idx    <= '0;
      done       <= 1'b0;
      done_idx   <= '0;
      done_code  <= '0;
      for (int i = 0; i < NUM_CMP; i++) bank[i] <= MID;
    end else begin
      done <= 1'b0;
      if (!last) begin
        cnt  <= cnt + 1'b1;
        acc  <= sum;
        chop <= ~chop;
      end else begin
        cnt  <= '0;
        acc  <= '0;
        chop <= 1'b0;
        if (bitp == '0) begin
          bank[sel_idx] <= decided;
          done          <= 1'b1;
          done_idx      <= sel_idx;
          done_code     <= decided;
          sel_idx       <= sel_next;
          trim_trial    <= MID;
          bitp          <= BIT_W'(TRIM_W - 1);
        end else begin
          trim_trial <= decided | (mask >> 1);
          bitp       <= bitp - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/offset_cal_ctrl_chk.sv
module offset_cal_ctrl_chk #(
  parameter int NUM_CMP = 63,
  parameter int TRIM_W  = 6,
  parameter int WIN_LEN = 1000,
  localparam int IDX_W  = $clog2(NUM_CMP)
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      chop,
  input logic [IDX_W-1:0]          sel_idx,
  input logic [TRIM_W-1:0]         trim_trial,
  input logic [NUM_CMP*TRIM_W-1:0] trim_bank,
  input logic                      done,
  input logic [IDX_W-1:0]          done_idx,
  input logic [TRIM_W-1:0]         done_code
);
  localparam logic [TRIM_W-1:0] MID = TRIM_W'(1) << (TRIM_W - 1);

  AST_CHOP_FALLS: assert property (@(posedge clk) disable iff (rst) chop |=> !chop); // R2
  AST_DONE_WINDOW_START: assert property (@(posedge clk) disable iff (rst) done |-> !chop); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R5
  AST_DONE_STORED: assert property (@(posedge clk) disable iff (rst)
    done |-> trim_bank[int'(done_idx)*TRIM_W +: TRIM_W] == done_code); // R6
  AST_TRIAL_RESTART: assert property (@(posedge clk) disable iff (rst) done |-> trim_trial == MID); // R4
  AST_SEL_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    done |-> sel_idx == ((done_idx == IDX_W'(NUM_CMP - 1)) ? '0 : done_idx + 1'b1)); // R7
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(sel_idx)) |-> done); // R7
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(trim_bank)) |-> done); // R9
endmodule

bind offset_cal_ctrl offset_cal_ctrl_chk #(
  .NUM_CMP(NUM_CMP), .TRIM_W(TRIM_W), .WIN_LEN(WIN_LEN)
) u_chk (.*);

// File: tb/offset_cal_ctrl_test.sv
module offset_cal_ctrl_test;
  localparam int N  = 5;
  localparam int TW = 6;
  localparam int WL = 8;
  localparam int IW = $clog2(N);
  localparam int ROWS = 10;
  localparam int OFFS [ROWS] = '{0, 5, -5, 40, -40, 31, -31, 32, 1, -1};
  localparam int EXPC [ROWS] = '{32, 27, 37, 0, 63, 1, 63, 0, 31, 33};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  cmp_dec;
  logic          chop;
  logic [IW-1:0] sel_idx;
  logic [TW-1:0] trim_trial;
  logic [N*TW-1:0] trim_bank;
  logic          done;
  logic [IW-1:0] done_idx;
  logic [TW-1:0] done_code;

  int checks = 0;
  int errors = 0;
  int wd = 0;
  int off [N];
  int exp_bank [N];
  logic [4:0] noise = 5'b10011;

  always #4 clk = ~clk;

  offset_cal_ctrl #(.NUM_CMP(N), .TRIM_W(TW), .WIN_LEN(WL)) uut (
    .clk(clk), .rst(rst), .cmp_dec(cmp_dec), .chop(chop), .sel_idx(sel_idx),
    .trim_trial(trim_trial), .trim_bank(trim_bank), .done(done),
    .done_idx(done_idx), .done_code(done_code));

  always @(negedge clk) noise <= {noise[3:0], noise[4] ^ noise[2]};

  always_comb begin
    for (int i = 0; i < N; i++) begin
      int res;
      res = off[i] + int'(trim_trial) - 32;
      if (i == int'(sel_idx)) cmp_dec[i] = chop ? (res < 0) : (res > 0);
      else cmp_dec[i] = noise[i];
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      chk(1'b0, "watchdog", wd, 20000);
      finish_run();
    end
  end

  task automatic check_reset_state();
    int bad = 0;
    for (int i = 0; i < N; i++) if (trim_bank[i*TW +: TW] != TW'(32)) bad++;
    chk(bad == 0, "R1 bank mid-scale", bad, 0);
    chk(sel_idx == 0, "R1 sel", int'(sel_idx), 0);
    chk(trim_trial == 32, "R1 trial", int'(trim_trial), 32);
    chk(chop == 0 && done == 0, "R1 chop/done", int'({chop, done}), 0);
  endtask

  task automatic run_cal(input int idx, input int code, input bit look48);
    int cyc = 0;
    int chop_bad = 0;
    forever begin
      if (cyc > 0 && done) break;
      if (cyc > 300) break;
      if (chop !== cyc[0]) chop_bad++;
      if (look48 && cyc == WL)
        chk(trim_trial == 48, "R4 MSB kept on zero sum, next bit set", int'(trim_trial), 48);
      @(negedge clk);
      cyc++;
    end
    chk(cyc == TW*WL, "R5 calibration length", cyc, TW*WL);
    chk(chop_bad == 0, "R2 chop pattern", chop_bad, 0);
    chk(int'(done_idx) == idx, "R6 done_idx", int'(done_idx), idx);
    chk(int'(done_code) == code, "R4 R3 R8 final code", int'(done_code), code);
    chk(int'(trim_bank[idx*TW +: TW]) == code, "R6 stored code", int'(trim_bank[idx*TW +: TW]), code);
    exp_bank[idx] = code;
    for (int i = 0; i < N; i++)
      if (i != idx) chk(int'(trim_bank[i*TW +: TW]) == exp_bank[i], "R9 other entries",
                        int'(trim_bank[i*TW +: TW]), exp_bank[i]);
    chk(int'(sel_idx) == (idx + 1) % N, "R7 index advance/wrap", int'(sel_idx), (idx + 1) % N);
    chk(trim_trial == 32, "R4 restart mid-scale", int'(trim_trial), 32);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      off[i] = OFFS[i];
      exp_bank[i] = 32;
    end
    repeat (3) @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    for (int k = 0; k < ROWS; k++) begin
      run_cal(k % N, EXPC[k], k == 0);
      if (k + N < ROWS) off[k % N] = OFFS[k + N];
    end
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_reset_state();
    for (int i = 0; i < N; i++) exp_bank[i] = 32;
    rst = 1'b0;
    run_cal(0, EXPC[5], 1'b0);
    finish_run();
  end
endmodule